// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the Ethernet MII management channel. It divides the system clock to produce MDC, and it drives or releases the shared MDIO line to run one PHY register read or one PHY register write per request. A host asserts a one-cycle `start` with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block answers with a one-cycle `done`, the 16-bit result of a read, and a `no_phy` flag.

Each frame opens with 32 MDC cycles of ones on MDIO. A header follows: a start pair, a two-bit opcode, the PHY address and the register address. On a write the master then drives the turnaround and the data word itself. On a read it lets go of the line and samples the turnaround bit. A high turnaround means no PHY answered. In that case the master runs a 32-cycle recovery burst with the line released, then reports all-ones data and raises `no_phy`. The incoming MDIO line passes through a two-flop synchronizer. Every sample is taken at the end of an MDC high phase, so `HALF_DIV` must be at least 3.

Top module: `mgmt_frame_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `mdc` is 0, `mdio_oe` is 0 and `done` is 0. Each frame starts with 32 MDC cycles in which the master drives MDIO to 1. After reset `rd_data` is 0 and `no_phy` is 0.
- R2: MDC cycles 32 to 45 of a frame carry the following bits, all driven and all sampled by the PHY at the MDC rising edge. First comes the start pair 0,1. Next is the opcode: 1,0 when `rd_nwr`=1 (read) and 0,1 when `rd_nwr`=0 (write). Then come `phy_addr` and then `reg_addr`, each with its MSB first.
- R3: A write drives the turnaround 1,0 in cycles 46 to 47 and `wr_data` MSB first in cycles 48 to 63. It then releases MDIO for one final cycle, which makes 65 MDC cycles in total.
- R4: MDIO changes only while MDC is low. The MDC high phase lasts `HALF_DIV` system clocks, and the MDC period is 2*`HALF_DIV` clocks.
- R5: A read releases MDIO from cycle 46 onward and samples the turnaround at the end of the high phase of cycle 46. If that sample is 0, 16 data bits are sampled MSB first in cycles 47 to 62. Two released cycles follow, which makes 65 cycles in total. The sampled word is then placed on `rd_data` with `no_phy`=0.
- R6: If the turnaround sample on a read is 1, the master issues 32 more released cycles, which makes 79 in total. It then finishes with `rd_data`=16'hFFFF and `no_phy`=1.
- R7: `done` is a single-cycle pulse. It rises in the same clock in which MDC falls for the last time, and `rd_data` and `no_phy` are already valid in that clock.
- R8: A `start` that arrives while a frame is in progress is ignored. The running frame keeps its bits and length, and no second frame follows it.
- R9: A write leaves `rd_data` unchanged and clears `no_phy` when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data to write |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | Sensed MDIO line level |
| rd_data | output | 16 | Result of the last read |
| done | output | 1 | One-cycle completion pulse |
| no_phy | output | 1 | Last read found no responding PHY |

## Verification
A wrong slot count or a bad shift register appears at the next MDC rising edge as a wrong header or data bit. It also shows as a frame with the wrong total number of MDC cycles, and both are visible within one frame. A fault in the turnaround decision or in the receive shift shows up at `done` as wrong `rd_data` or a wrong `no_phy` value. It also changes the frame length from 65 to 79 cycles, or the reverse. Faults in the divider or in the guard on the output enable show within a single MDC period, as a wrong high-phase length or as MDIO changing while MDC is high.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  parameter int PHY_AW    = 5;
  parameter int REG_AW    = 5;
  parameter int DATA_W    = 16;
  parameter int PRE_LEN   = 32;
  parameter int RECOV_LEN = 32;
  parameter int RD_TAIL   = 2;
  parameter int WR_TAIL   = 1;

  // header = preamble + start pair + opcode + two addresses
  localparam int HDR_W = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int WR_W  = HDR_W + 2 + DATA_W;
  localparam int CNT_W = $clog2(WR_W);

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_PAT  = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_TA, S_RX, S_TAIL} seq_st_t;

  function automatic logic [WR_W-1:0] build_frame(
      input logic              rd,
      input logic [PHY_AW-1:0] pa,
      input logic [REG_AW-1:0] ra,
      input logic [DATA_W-1:0] wd);
    build_frame = {{PRE_LEN{1'b1}}, SOF_PAT, (rd ? OP_RD : OP_WR), pa, ra, TA_PAT, wd};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic fall_tk
);
  localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] cnt, cnt_n;
  logic             mdc_n, tk;

  assign tk      = run && (cnt == DIV_LAST);
  assign fall_tk = tk && mdc;

  always_comb begin
    cnt_n = cnt;
    mdc_n = mdc;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tk) begin
      cnt_n = '0;
      mdc_n = !mdc;
    end else begin
      cnt_n = cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_n;
      mdc <= mdc_n;
    end
  end

  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mgmt_sync2.sv
module mgmt_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      dout <= 1'b1;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mdc,
  input  logic              fall_tk,
  input  logic              mdio_s,
  output logic              run,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              no_phy
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_W - 1);
  localparam logic [CNT_W-1:0] RX_LAST   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] RD_TL     = CNT_W'(RD_TAIL - 1);
  localparam logic [CNT_W-1:0] WR_TL     = CNT_W'(WR_TAIL - 1);
  localparam logic [CNT_W-1:0] RECOV_TL  = CNT_W'(RECOV_LEN - 1);

  seq_st_t           st, st_n;
  logic [WR_W-1:0]   sh, sh_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] rx, rx_n, rdat_n;
  logic              is_rd, rd_n, miss, miss_n, oe_n, err_n, done_n;

  assign run      = (st != S_IDLE);
  assign mdio_out = sh[WR_W-1];

  always_comb begin
    st_n   = st;
    sh_n   = sh;
    cnt_n  = cnt;
    rx_n   = rx;
    rd_n   = is_rd;
    miss_n = miss;
    oe_n   = mdio_oe;
    rdat_n = rd_data;
    err_n  = no_phy;
    done_n = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        st_n   = S_TX;
        sh_n   = build_frame(rd_nwr, phy_addr, reg_addr, wr_data);
        cnt_n  = '0;
        rd_n   = rd_nwr;
        miss_n = 1'b0;
        oe_n   = 1'b1;
      end
      S_TX: if (fall_tk) begin
        sh_n  = sh << 1;
        cnt_n = cnt + CNT_W'(1);
        if (is_rd && cnt == HDR_LAST) begin
          st_n = S_TA;
          oe_n = 1'b0;
        end else if (!is_rd && cnt == WR_LAST) begin
          st_n  = S_TAIL;
          oe_n  = 1'b0;
          cnt_n = WR_TL;
        end
      end
      S_TA: if (fall_tk) begin
        if (mdio_s) begin
          st_n   = S_TAIL;
          miss_n = 1'b1;
          cnt_n  = RECOV_TL;
        end else begin
          st_n  = S_RX;
          cnt_n = '0;
        end
      end
      S_RX: if (fall_tk) begin
        rx_n  = {rx[DATA_W-2:0], mdio_s};
        cnt_n = cnt + CNT_W'(1);
        if (cnt == RX_LAST) begin
          st_n  = S_TAIL;
          cnt_n = RD_TL;
        end
      end
      S_TAIL: if (fall_tk) begin
        if (cnt == '0) begin
          st_n   = S_IDLE;
          done_n = 1'b1;
          err_n  = is_rd && miss;
          if (is_rd) rdat_n = miss ? '1 : rx;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rx      <= '0;
      is_rd   <= 1'b0;
      miss    <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
      no_phy  <= 1'b0;
      done    <= 1'b0;
    end else begin
      st      <= st_n;
      sh      <= sh_n;
      cnt     <= cnt_n;
      rx      <= rx_n;
      is_rd   <= rd_n;
      miss    <= miss_n;
      mdio_oe <= oe_n;
      rd_data <= rdat_n;
      no_phy  <= err_n;
      done    <= done_n;
    end
  end

  // R4
  mdio_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> !mdc);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mdio_oe);

  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX || st == S_TA) |-> !mdio_oe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  absent_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_phy) |-> (rd_data == '1));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && start && !fall_tk) |=> $stable(sh));
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              no_phy
);
  logic run, fall_tk, mdio_s;

  mgmt_mdc_gen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mdc     (mdc),
    .fall_tk (fall_tk)
  );

  mgmt_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mdio_in),
    .dout  (mdio_s)
  );

  mgmt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_nwr   (rd_nwr),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .mdc      (mdc),
    .fall_tk  (fall_tk),
    .mdio_s   (mdio_s),
    .run      (run),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data),
    .done     (done),
    .no_phy   (no_phy)
  );
endmodule

// File: tb/sim_mgmt_frame_master.sv
module sim_mgmt_frame_master;
  localparam int HD = 4;

  logic        clk, rst_n, start, rd_nwr, mdio_in;
  logic [4:0]  pa, ra;
  logic [15:0] wd;
  logic        mdc, mdio_out, mdio_oe, done, no_phy;
  logic [15:0] rd_data;

  mgmt_frame_master #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(pa), .reg_addr(ra), .wr_data(wd),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
    .rd_data(rd_data), .done(done), .no_phy(no_phy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(negedge clk) cyc++;

  // PHY model: captures master bits at MDC rise, drives its reply after MDC fall
  int   rise_n = 0, fall_n = 0, last_rise = 0, per = 0, hi = 0;
  logic cap_v [0:127];
  logic cap_e [0:127];
  logic phy_rd = 1'b0, phy_here = 1'b0, phy_drv = 1'b0, phy_bit = 1'b1;
  logic [15:0] phy_val = '0;
  logic [15:0] exp_rd = '0;

  assign mdio_in = mdio_oe ? mdio_out : (phy_drv ? phy_bit : 1'b1);

  always @(posedge mdc) begin
    if (rise_n < 128) begin
      cap_v[rise_n] = mdio_out;
      cap_e[rise_n] = mdio_oe;
    end
    rise_n++;
    per = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge mdc) begin
    fall_n++;
    hi = cyc - last_rise;
    phy_drv = 1'b0;
    if (phy_rd && phy_here) begin
      if (fall_n == 46) begin
        phy_drv = 1'b1;
        phy_bit = 1'b0;
      end else if (fall_n >= 47 && fall_n <= 62) begin
        phy_drv = 1'b1;
        phy_bit = phy_val[62 - fall_n];
      end
    end
  end

  // {rd, phy present, phy addr, reg addr, data}
  localparam logic [27:0] VEC [6] = '{
    {1'b1, 1'b1, 5'h01, 5'h02, 16'hA5C3},
    {1'b0, 1'b0, 5'h1F, 5'h00, 16'h8001},
    {1'b1, 1'b1, 5'h00, 5'h1F, 16'h7FFE},
    {1'b1, 1'b0, 5'h0A, 5'h15, 16'h1234},
    {1'b0, 1'b0, 5'h15, 5'h0A, 16'hFFFF},
    {1'b1, 1'b1, 5'h10, 5'h01, 16'h0001}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i, input logic r, input logic [4:0] p,
                                   input logic [4:0] g, input logic [15:0] d);
    if (i < 32)       return 1'b1;
    else if (i == 32) return 1'b0;
    else if (i == 33) return 1'b1;
    else if (i == 34) return r;
    else if (i == 35) return !r;
    else if (i <= 40) return p[40 - i];
    else if (i <= 45) return g[45 - i];
    else if (i == 46) return 1'b1;
    else if (i == 47) return 1'b0;
    else              return d[63 - i];
  endfunction

  task automatic run_txn(input logic r, input logic here, input logic [4:0] p,
                         input logic [4:0] g, input logic [15:0] d, input bit inject);
    int n_exp, hdr_bits, frm_bad, pre_bad, waited;
    @(negedge clk);
    rise_n = 0; fall_n = 0; phy_drv = 1'b0;
    phy_rd = r; phy_here = here; phy_val = d;
    rd_nwr = r; pa = p; ra = g; wd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      if (inject && waited == 30) begin
        rd_nwr = !r; pa = ~p; ra = ~g; wd = ~d; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    chk(done, "R7", "done seen before timeout", done, 1);
    n_exp    = !r ? 65 : (here ? 65 : 79);
    hdr_bits = r ? 46 : 64;
    frm_bad = 0; pre_bad = 0;
    for (int i = 0; i < n_exp; i++) begin
      if (i < 32) begin
        if (!cap_e[i] || cap_v[i] !== 1'b1) pre_bad++;
      end else if (i < hdr_bits) begin
        if (!cap_e[i] || cap_v[i] !== exp_bit(i, r, p, g, d)) frm_bad++;
      end else if (cap_e[i]) begin
        frm_bad++;
      end
    end
    chk(pre_bad == 0, "R1", "preamble bit errors", pre_bad, 0);
    chk(frm_bad == 0, r ? "R2" : "R3", "frame bit errors", frm_bad, 0);
    chk(rise_n == n_exp, r ? (here ? "R5" : "R6") : "R3", "MDC cycles", rise_n, n_exp);
    chk(per == 2*HD && hi == HD, "R4", "MDC period/high", per*100 + hi, 2*HD*100 + HD);
    if (r) begin
      exp_rd = here ? d : 16'hFFFF;
      chk(rd_data == exp_rd, here ? "R5" : "R6", "read data", rd_data, exp_rd);
      chk(no_phy == !here, here ? "R5" : "R6", "no_phy", no_phy, !here);
    end else begin
      chk(rd_data == exp_rd, "R9", "rd_data kept by write", rd_data, exp_rd);
      chk(no_phy == 1'b0, "R9", "no_phy cleared by write", no_phy, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", done, 0);
    chk(mdio_oe == 1'b0 && mdc == 1'b0, "R1", "idle mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_nwr = 1'b0; pa = '0; ra = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mdc == 1'b0, "R1", "reset mdc", mdc, 0);
    chk(mdio_oe == 1'b0, "R1", "reset oe", mdio_oe, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(rd_data == 16'h0 && no_phy == 1'b0, "R1", "reset outputs", {no_phy, rd_data}, 0);

    for (int k = 0; k < 6; k++)
      run_txn(VEC[k][27], VEC[k][26], VEC[k][25:21], VEC[k][20:16], VEC[k][15:0], 1'b0);

    // R8: start while busy on a write, then on a read with absent PHY
    run_txn(1'b0, 1'b0, 5'h03, 5'h11, 16'h5A5A, 1'b1);
    repeat (300) @(negedge clk);
    chk(rise_n == 65, "R8", "no extra frame after write", rise_n, 65);
    run_txn(1'b1, 1'b0, 5'h1C, 5'h07, 16'h0F0F, 1'b1);
    repeat (300) @(negedge clk);
    chk(rise_n == 79, "R8", "no extra frame after read", rise_n, 79);
    chk(mdio_oe == 1'b0 && mdc == 1'b0, "R8", "stays idle", {mdc, mdio_oe}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule